// File: doc/BRIEF.md
# Two-Wire 16-Bit Port Expander Slave

This block is a slave on a two-wire serial bus that gives a host sixteen general-purpose pins. The pins are organised as a low byte and a high byte. The block samples the bus clock and data lines with its own system clock. It pulls the data line low through an open-drain enable. Three strap inputs set the low bits of its 7-bit bus address.

A write transaction fills the output latches. Data bytes alternate between the low and the high byte. Each latch byte changes only once its byte has been acknowledged. A read transaction returns the sampled pin levels in the same low/high alternation, for as long as the master keeps acknowledging. A stop or a repeated start may cut a transaction short at any bit. When that happens, the partial byte is thrown away and the latches keep what they last received.

An active-low interrupt tells the host that the pins no longer match the levels it last accessed. Any read or write of port data clears it.

Top module: `i2c_port_expander16`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal binary 0100 followed by `strap_addr[2:0]`, with the last bit selecting the direction (0 write, 1 read). For any other address it never pulls SDA low, and it ignores the bus until the next start.
- R2: In a write, data bytes go alternately to `port_out[7:0]` and `port_out[15:8]`, starting with the low byte, for any number of pairs. Each byte arrives most significant bit first.
- R3: During a write to a matching address, the block pulls SDA low through the acknowledge clock of every data byte.
- R4: An output latch byte changes at the SCL falling edge that ends the eighth bit of its data byte. It holds its old value while the bits are still arriving.
- R5: In a read, the block returns `port_in[7:0]` and then `port_in[15:8]`, most significant bit first, repeating the pair while the master acknowledges. After a byte that is not acknowledged, the block releases SDA.
- R6: Each read byte carries the pin levels sampled at the SCL falling edge that starts its first bit. Pin changes later in that byte do not alter it.
- R7: A stop condition (SDA rising while SCL is high) at any bit ends the transfer. A partially received byte is discarded, and the latches keep their last acknowledged value.
- R8: A start condition (SDA falling while SCL is high) at any point returns the block to address reception. The next data byte then goes to, or comes from, the low byte again.
- R9: `int_n` goes low while the sampled pins differ from a reference. The reference is reloaded with the pins at every read byte capture and every write data acknowledge, so `int_n` returns high after an access, or when the pins return to the reference.
- R10: After reset, `port_out` is all ones, SDA is released, and `int_n` is high while the pins read all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_drive_low | output | 1 | Open-drain enable, 1 pulls SDA low |
| strap_addr | input | 3 | Low three address bits from straps |
| port_in | input | 16 | Pin levels, high byte in bits 15..8 |
| port_out | output | 16 | Output latches, high byte in bits 15..8 |
| int_n | output | 1 | Active-low pin-change interrupt |

## Verification
The bench aborts a write with a stop four bits into the second byte, then starts a fresh write. A design that kept the half byte, or kept its byte pointer across transactions, would corrupt the high latch or send the new byte to the wrong half. It changes the pins just after the first bit of a read byte. A design that sampled the pins per bit would return a mixed byte. It also checks the latches at the last bit before the acknowledge, which catches a design that updates early. Finally, it returns the pins to the last-read value and expects the interrupt to clear without any access, which fails if the interrupt is a sticky change flag.

// File: rtl/i2c_port_expander16.sv
module i2c_port_expander16 #(
  parameter int          SYNC_STAGES = 2,
  parameter logic [3:0]  ADDR_PREFIX = 4'b0100,
  parameter logic [15:0] OUT_RESET   = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        sda_drive_low,
  input  logic [2:0]  strap_addr,
  input  logic [15:0] port_in,
  output logic [15:0] port_out,
  output logic        int_n
);

  localparam int CW = 4;
  localparam logic [CW-1:0] BYTE_BITS = CW'(8);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK, S_WR, S_WR_ACK, S_RD, S_RD_ACK
  } state_t;

  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_s, sda_s, scl_d, sda_d;
  logic scl_rise, scl_fall, bus_start, bus_stop;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [7:0]    shreg, tx;
  logic          hi_sel, rw, m_ack;
  logic [15:0]   pin_q, ref_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_in};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_in};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  assign scl_s     = scl_sh[SYNC_STAGES-1];
  assign sda_s     = sda_sh[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign bus_start = scl_s & scl_d & sda_d & ~sda_s;
  assign bus_stop  = scl_s & scl_d & ~sda_d & sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      tx       <= '1;
      hi_sel   <= 1'b0;
      rw       <= 1'b0;
      m_ack    <= 1'b0;
      pin_q    <= '1;
      ref_q    <= '1;
      port_out <= OUT_RESET;
      int_n    <= 1'b1;
    end else begin
      pin_q <= port_in;
      int_n <= (pin_q == ref_q);
      if (bus_start) begin
        st     <= S_ADDR;
        cnt    <= '0;
        hi_sel <= 1'b0;
      end else if (bus_stop) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_ADDR, S_WR: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == BYTE_BITS) begin
              if (st == S_ADDR) begin
                if (shreg[7:1] == {ADDR_PREFIX, strap_addr}) begin
                  st <= S_ADDR_ACK;
                  rw <= shreg[0];
                end else begin
                  st <= S_IDLE;
                end
              end else begin
                st    <= S_WR_ACK;
                ref_q <= pin_q;
                if (hi_sel) port_out[15:8] <= shreg;
                else        port_out[7:0]  <= shreg;
              end
            end
          end
          S_ADDR_ACK: begin
            if (scl_fall) begin
              cnt    <= '0;
              hi_sel <= 1'b0;
              if (rw) begin
                st    <= S_RD;
                tx    <= pin_q[7:0];
                ref_q <= pin_q;
              end else begin
                st <= S_WR;
              end
            end
          end
          S_WR_ACK: begin
            if (scl_fall) begin
              st     <= S_WR;
              cnt    <= '0;
              hi_sel <= ~hi_sel;
            end
          end
          S_RD: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == BYTE_BITS) st <= S_RD_ACK;
              else                  tx <= {tx[6:0], 1'b1};
            end
          end
          S_RD_ACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (m_ack) begin
                st     <= S_RD;
                cnt    <= '0;
                hi_sel <= ~hi_sel;
                tx     <= hi_sel ? pin_q[7:0] : pin_q[15:8];
                ref_q  <= pin_q;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign sda_drive_low = (st == S_ADDR_ACK) | (st == S_WR_ACK) |
                         ((st == S_RD) & ~tx[7]);

endmodule

module i2c_port_expander16_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_s,
  input logic        scl_fall,
  input logic        sda_drive_low,
  input logic        hi_sel,
  input logic [3:0]  cnt,
  input logic [15:0] port_out
);

  assert_out_at_scl_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(port_out) |-> $past(scl_fall));

  assert_drive_while_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low) |-> !scl_s);

  assert_high_byte_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(port_out[15:8]) |-> $past(hi_sel));

  assert_low_byte_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(port_out[7:0]) |-> !$past(hi_sel));

  assert_bit_count_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 4'd8);

endmodule

bind i2c_port_expander16 i2c_port_expander16_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_fall(scl_fall),
  .sda_drive_low(sda_drive_low), .hi_sel(hi_sel), .cnt(cnt),
  .port_out(port_out)
);

// File: tb/test_i2c_port_expander16.sv
`timescale 1ns/1ps
module test_i2c_port_expander16;
  localparam int H = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic [2:0] strap = 3'b101;
  logic [15:0] port_in = 16'hFFFF;
  logic [15:0] port_out;
  logic sda_drive_low, int_n, sda_bus;
  logic [15:0] pre_ack_out;
  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;
  assign sda_bus = m_sda & ~sda_drive_low;

  i2c_port_expander16 i_i2c_port_expander16 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus),
    .sda_drive_low(sda_drive_low), .strap_addr(strap),
    .port_in(port_in), .port_out(port_out), .int_n(int_n)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_clk(H);
    scl = 1'b1;   wait_clk(H);
    m_sda = 1'b0; wait_clk(H);
    scl = 1'b0;
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_clk(H);
    scl = 1'b1;   wait_clk(H);
    m_sda = 1'b1; wait_clk(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      m_sda = b[i]; wait_clk(H);
      scl = 1'b1;   wait_clk(H);
      if (i == 0) pre_ack_out = port_out;
      scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    m_sda = 1'b1; wait_clk(H);
    scl = 1'b1;   wait_clk(H/2);
    ack = ~sda_bus;
    wait_clk(H - H/2);
    scl = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic give_ack,
                           input logic poke, input logic [15:0] pv);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_clk(H);
      scl = 1'b1; wait_clk(H/2);
      b[i] = sda_bus;
      if (i == 7 && poke) port_in = pv;
      wait_clk(H - H/2);
      scl = 1'b0;
    end
    m_sda = ~give_ack; wait_clk(H);
    scl = 1'b1;        wait_clk(H);
    scl = 1'b0;
    m_sda = 1'b1;
  endtask

  task automatic t_reset();
    check("R10 port_out", port_out, 16'hFFFF);
    check("R10 sda released", {15'd0, sda_drive_low}, 16'd0);
    check("R10 int_n", {15'd0, int_n}, 16'd1);
  endtask

  task automatic t_write_pairs();
    logic ack;
    bus_start();
    send_byte(8'h4A, ack);
    check("R1 address ack", {15'd0, ack}, 16'd1);
    send_byte(8'h5A, ack);
    check("R3 data ack", {15'd0, ack}, 16'd1);
    check("R4 no early update", pre_ack_out, 16'hFFFF);
    check("R2 low byte", port_out, 16'hFF5A);
    send_byte(8'hC3, ack);
    check("R3 data ack", {15'd0, ack}, 16'd1);
    check("R4 low byte held before ack", pre_ack_out, 16'hFF5A);
    check("R2 high byte", port_out, 16'hC35A);
    send_byte(8'h01, ack);
    check("R2 second pair low", port_out, 16'hC301);
    send_byte(8'h80, ack);
    check("R2 second pair high", port_out, 16'h8001);
    bus_stop();
    check("R2 after stop", port_out, 16'h8001);
  endtask

  task automatic t_addr_mismatch();
    logic ack;
    bus_start();
    send_byte(8'h4C, ack);
    check("R1 mismatch no ack", {15'd0, ack}, 16'd0);
    send_byte(8'h00, ack);
    check("R1 ignored data no ack", {15'd0, ack}, 16'd0);
    check("R1 ignored data no write", port_out, 16'h8001);
    bus_stop();
  endtask

  task automatic t_read();
    logic ack;
    logic [7:0] b;
    port_in = 16'h1234;
    bus_start();
    send_byte(8'h4B, ack);
    check("R1 read address ack", {15'd0, ack}, 16'd1);
    recv_byte(b, 1'b1, 1'b0, 16'h0);
    check("R5 first byte low pins", {8'd0, b}, 16'h0034);
    recv_byte(b, 1'b1, 1'b0, 16'h0);
    check("R5 second byte high pins", {8'd0, b}, 16'h0012);
    port_in = 16'hBEEF;
    recv_byte(b, 1'b1, 1'b0, 16'h0);
    check("R5 repeat pair low", {8'd0, b}, 16'h00EF);
    recv_byte(b, 1'b0, 1'b0, 16'h0);
    check("R5 repeat pair high", {8'd0, b}, 16'h00BE);
    wait_clk(5);
    check("R5 release after nack", {15'd0, sda_drive_low}, 16'd0);
    bus_stop();
  endtask

  task automatic t_capture();
    logic ack;
    logic [7:0] b;
    port_in = 16'h1234;
    wait_clk(4);
    bus_start();
    send_byte(8'h4B, ack);
    recv_byte(b, 1'b1, 1'b1, 16'hABCD);
    check("R6 byte frozen at first bit", {8'd0, b}, 16'h0034);
    recv_byte(b, 1'b0, 1'b0, 16'h0);
    check("R6 next byte sees new pins", {8'd0, b}, 16'h00AB);
    bus_stop();
  endtask

  task automatic t_stop_midbyte();
    logic ack;
    bus_start();
    send_byte(8'h4A, ack);
    send_byte(8'h77, ack);
    check("R7 full byte kept", port_out, 16'h8077);
    send_bits(8'h00, 4);
    bus_stop();
    check("R7 partial byte discarded", port_out, 16'h8077);
    bus_start();
    send_byte(8'h4A, ack);
    send_bits(8'h00, 5);
    bus_stop();
    check("R7 partial first byte discarded", port_out, 16'h8077);
    bus_start();
    send_byte(8'h4A, ack);
    send_byte(8'h11, ack);
    send_byte(8'h22, ack);
    bus_stop();
    check("R7 next write starts at low byte", port_out, 16'h2211);
  endtask

  task automatic t_rep_start();
    logic ack;
    bus_start();
    send_byte(8'h4A, ack);
    send_byte(8'h33, ack);
    check("R8 first byte low", port_out, 16'h2233);
    bus_start();
    send_byte(8'h4A, ack);
    check("R8 address after repeated start", {15'd0, ack}, 16'd1);
    send_byte(8'h44, ack);
    check("R8 pointer back to low byte", port_out, 16'h2244);
    send_byte(8'h55, ack);
    check("R8 then high byte", port_out, 16'h5544);
    bus_stop();
  endtask

  task automatic t_interrupt();
    logic ack;
    logic [7:0] b;
    port_in = 16'hF0F0;
    wait_clk(4);
    bus_start();
    send_byte(8'h4B, ack);
    recv_byte(b, 1'b0, 1'b0, 16'h0);
    bus_stop();
    check("R9 high after read", {15'd0, int_n}, 16'd1);
    port_in = 16'hF0F1;
    wait_clk(5);
    check("R9 low on pin change", {15'd0, int_n}, 16'd0);
    port_in = 16'hF0F0;
    wait_clk(5);
    check("R9 high when pins return", {15'd0, int_n}, 16'd1);
    port_in = 16'h00F0;
    wait_clk(5);
    check("R9 low on high byte change", {15'd0, int_n}, 16'd0);
    bus_start();
    send_byte(8'h4A, ack);
    send_byte(8'h66, ack);
    bus_stop();
    check("R9 cleared by write", {15'd0, int_n}, 16'd1);
    port_in = 16'h0000;
    wait_clk(5);
    check("R9 low again", {15'd0, int_n}, 16'd0);
    bus_start();
    send_byte(8'h4B, ack);
    recv_byte(b, 1'b0, 1'b0, 16'h0);
    bus_stop();
    check("R9 cleared by read", {15'd0, int_n}, 16'd1);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    finish_run();
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_write_pairs();
    t_addr_mismatch();
    t_read();
    t_capture();
    t_stop_midbyte();
    t_rep_start();
    t_interrupt();
    finish_run();
  end
endmodule